// File: doc/BRIEF.md
# Multi-Bank Flash Operation Arbiter

This block decides, for a multi-bank NOR flash array of 16M words, which requests the array may accept at any moment. Each request arrives as a one-cycle command strobe with an opcode and a word address. The block answers in the same cycle with a grant or a reject flag. It remembers the single bank and block that are busy with a program or an erase, and whether that operation is suspended.

The array has 16 banks of 1M words. Fifteen of them hold sixteen 64K-word main blocks each. The remaining bank holds four 16K-word parameter blocks and fifteen main blocks, which gives 259 blocks. A static configuration input places the parameter bank at the top or at the bottom of the address space. The block turns every address into a bank index and a block index for either layout.

Only one bank may program or erase at a time, and reads are served from every other bank while it does. An erase may be suspended so that other blocks can be read or programmed, and that nested program may itself be suspended. A program may be suspended to read anything except the word being written. A done pulse from the program/erase controller closes the running operation.

Top module: `flash_bank_arbiter`

## Requirements
- R1: The bank index is address bits [23:20]; `busy_bank` shows the bank of the operation in progress, and `busy`, `busy_bank`, `busy_block`, `ers_susp` and `pgm_susp` are all 0 while idle.
- R2: With `param_top`=0, bank 0 words 0x000000-0x00FFFF are parameter blocks 0-3 (block = address bits [15:14]), and every other 64K slot of bank b at slot s (bits [19:16]) is block 3+16*b+s, so 0xFF0000 is block 258.
- R3: With `param_top`=1, slot s of bank b is block 16*b+s, except slot 15 of bank 15, whose four 16K parameter blocks are blocks 255-258 (255 + bits [15:14]).
- R4: Opcodes are read=0, program=1, erase=2, suspend=3, resume=4. A command never raises grant and reject together, and opcodes 5-7 are always rejected.
- R5: While idle, read, program and erase are granted. A granted program or erase shows `busy`=1 with its bank and block from the next cycle.
- R6: While a program or erase runs unsuspended, a read to another bank is granted and a read to the busy bank is rejected.
- R7: An erase start is rejected whenever any operation is active or suspended. A program start is rejected in the same cases, except as allowed by R9.
- R8: A suspend is granted only while a program or erase runs and `done` is low; it sets `pgm_susp` or `ers_susp` from the next cycle. A resume is granted only while something is suspended and clears that flag, restoring the operation it resumes.
- R9: While an erase is suspended, reads and program starts are granted in every block except the erase block, where both are rejected. A nested program shows as the busy operation with `ers_susp` still 1. During it, reads are granted only outside its bank and outside the erase block, and a resume is rejected. Its done pulse returns to the suspended erase.
- R10: While a program is suspended, a read is granted unless its address equals the word being programmed, or, for a nested program, it falls in the suspended erase block.
- R11: A resume while nothing is suspended raises neither flag and changes no output.
- R12: `done` while a program or erase runs ends it in the next cycle (idle, or back to the suspended erase for a nested program). `done` is ignored while idle or suspended.
- R13: A synchronous active-low reset returns the block to idle with every output state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| param_top | input | 1 | 1: parameter bank at top of address space; 0: at bottom |
| cmd_valid | input | 1 | Command strobe, one cycle per request |
| cmd_op | input | 3 | Opcode: 0 read, 1 program, 2 erase, 3 suspend, 4 resume |
| cmd_addr | input | 24 | Word address of the request |
| done | input | 1 | Running program or erase has finished |
| grant | output | 1 | Request accepted (combinational, same cycle) |
| reject | output | 1 | Request refused (combinational, same cycle) |
| busy | output | 1 | A program or erase is active or suspended |
| busy_bank | output | 4 | Bank of the shown operation |
| busy_block | output | 9 | Block index of the shown operation |
| ers_susp | output | 1 | An erase is suspended |
| pgm_susp | output | 1 | A program is suspended |

## Verification
Grant and reject are combinational, so the bench drives each request just after a falling edge and samples both flags 2 ns later, in the same cycle. Busy, bank, block and both suspend flags come from a single register stage and are due one rising edge after the request or done pulse. The bench reads them 1 ns after that edge, before the next request is driven. The vector table chains complete sequences through both layouts, so the state each step depends on is always the one the previous step left behind.

// File: rtl/flash_arb_pkg.sv
// Package: shared opcode and state encodings for the flash operation arbiter.
// Assumes: the opcode values are fixed by the command interface (see R4).
package flash_arb_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } cmd_op_e;

    // Arbiter states: plain program/erase, their suspended forms, and a
    // program nested inside a suspended erase (running or suspended).
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PGM   = 3'd1,
        ST_PSUS  = 3'd2,
        ST_ERS   = 3'd3,
        ST_ESUS  = 3'd4,
        ST_NPGM  = 3'd5,
        ST_NPSUS = 3'd6
    } arb_state_e;

endpackage

// File: rtl/flash_addr_decode.sv
// Module: flash_addr_decode
// Turns a word address into a bank index and a global block index for either
// parameter-bank placement. Purely combinational.
// Assumes: every bank holds 2**SLOT_W main slots; the parameter bank splits
// one slot into NPARAM small blocks; param_top is static while busy.
module flash_addr_decode #(
    parameter int ADDR_W  = 24,
    parameter int BANK_W  = 4,
    parameter int MAIN_W  = 16,
    parameter int PARAM_W = 14,
    parameter int BLK_W   = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              param_top,
    output logic [BANK_W-1:0] bank,
    output logic [BLK_W-1:0]  block
);
    localparam int OFF_W   = ADDR_W - BANK_W;
    localparam int SLOT_W  = OFF_W - MAIN_W;
    localparam int PSEL_W  = MAIN_W - PARAM_W;
    localparam int NPARAM  = 1 << PSEL_W;
    localparam int NMAINSL = (1 << BANK_W) * (1 << SLOT_W);
    localparam logic [BLK_W-1:0] BOT_OFS = BLK_W'(NPARAM - 1);
    localparam logic [BLK_W-1:0] TOP_PB0 = BLK_W'(NMAINSL - 1);

    logic [SLOT_W-1:0] slot;
    logic [PSEL_W-1:0] psel;
    logic [BLK_W-1:0]  linear;
    logic              bot_param;
    logic              top_param;
    logic [BLK_W-1:0]  blk_bot;
    logic [BLK_W-1:0]  blk_top;

    // Split the address into its bank, slot and parameter-select fields.
    always_comb begin
        bank   = addr[ADDR_W-1:OFF_W];
        slot   = addr[OFF_W-1:MAIN_W];
        psel   = addr[MAIN_W-1:PARAM_W];
        linear = BLK_W'({bank, slot});
    end

    // Locate the split slot for each layout (lowest or highest slot).
    always_comb begin
        bot_param = (bank == '0) && (slot == '0);
        top_param = (bank == '1) && (slot == '1);
    end

    // Block index when the parameter blocks sit at the bottom.
    always_comb begin
        if (bot_param) blk_bot = BLK_W'(psel);
        else           blk_bot = BOT_OFS + linear;
    end

    // Block index when the parameter blocks sit at the top.
    always_comb begin
        if (top_param) blk_top = TOP_PB0 + BLK_W'(psel);
        else           blk_top = linear;
    end

    // Choose the configured layout.
    always_comb block = param_top ? blk_top : blk_bot;

endmodule

// File: rtl/flash_arb_decide.sv
// Module: flash_arb_decide
// Resolves one request against the current state: grant or reject in the same
// cycle, plus the next state and the capture enables for the operation
// registers. Purely combinational.
// Assumes: done only has meaning in a running (unsuspended) state.
module flash_arb_decide
    import flash_arb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 4,
    parameter int BLK_W  = 9
) (
    input  arb_state_e        state,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              done,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [BLK_W-1:0]  cmd_block,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [BANK_W-1:0] pgm_bank,
    input  logic [BANK_W-1:0] ers_bank,
    input  logic [BLK_W-1:0]  ers_block,
    output logic              grant,
    output logic              reject,
    output logic              ld_pgm,
    output logic              ld_ers,
    output arb_state_e        nxt_state
);
    logic hit_word, hit_pbank, hit_ebank, hit_eblk;
    logic rd_ok, pg_ok, er_ok, sp_ok, rs_ok, rs_ign;

    // Address comparisons against the stored operations.
    always_comb begin
        hit_word  = (cmd_addr == pgm_addr);
        hit_pbank = (cmd_bank == pgm_bank);
        hit_ebank = (cmd_bank == ers_bank);
        hit_eblk  = (cmd_block == ers_block);
    end

    // Permission of each opcode in the current state.
    always_comb begin
        rd_ok  = 1'b0;
        pg_ok  = 1'b0;
        er_ok  = 1'b0;
        sp_ok  = 1'b0;
        rs_ok  = 1'b0;
        rs_ign = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rd_ok  = 1'b1;
                pg_ok  = 1'b1;
                er_ok  = 1'b1;
                rs_ign = 1'b1;
            end
            ST_PGM: begin
                rd_ok  = !hit_pbank;
                sp_ok  = !done;
                rs_ign = 1'b1;
            end
            ST_PSUS: begin
                rd_ok = !hit_word;
                rs_ok = 1'b1;
            end
            ST_ERS: begin
                rd_ok  = !hit_ebank;
                sp_ok  = !done;
                rs_ign = 1'b1;
            end
            ST_ESUS: begin
                rd_ok = !hit_eblk;
                pg_ok = !hit_eblk;
                rs_ok = 1'b1;
            end
            ST_NPGM: begin
                rd_ok = !hit_pbank && !hit_eblk;
                sp_ok = !done;
            end
            ST_NPSUS: begin
                rd_ok = !hit_word && !hit_eblk;
                rs_ok = 1'b1;
            end
            default: begin
                rd_ok = 1'b0;
            end
        endcase
    end

    // Map the opcode onto its permission: grant, reject or ignore.
    always_comb begin
        grant  = 1'b0;
        reject = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_READ:   begin grant = rd_ok; reject = !rd_ok; end
                OP_PROG:   begin grant = pg_ok; reject = !pg_ok; end
                OP_ERASE:  begin grant = er_ok; reject = !er_ok; end
                OP_SUSP:   begin grant = sp_ok; reject = !sp_ok; end
                OP_RESUME: begin
                    grant  = rs_ok;
                    reject = !rs_ok && !rs_ign;
                end
                default:   begin grant = 1'b0; reject = 1'b1; end
            endcase
        end
    end

    // Capture enables for the program and erase target registers.
    always_comb begin
        ld_pgm = grant && (cmd_op == OP_PROG);
        ld_ers = grant && (cmd_op == OP_ERASE);
    end

    // Next state: completion first, then any granted state-changing request.
    always_comb begin
        nxt_state = state;
        if (done) begin
            case (state)
                ST_PGM:  nxt_state = ST_IDLE;
                ST_ERS:  nxt_state = ST_IDLE;
                ST_NPGM: nxt_state = ST_ESUS;
                default: nxt_state = state;
            endcase
        end
        if (grant) begin
            case (cmd_op)
                OP_PROG:  nxt_state = (state == ST_ESUS) ? ST_NPGM : ST_PGM;
                OP_ERASE: nxt_state = ST_ERS;
                OP_SUSP: begin
                    case (state)
                        ST_PGM:  nxt_state = ST_PSUS;
                        ST_ERS:  nxt_state = ST_ESUS;
                        ST_NPGM: nxt_state = ST_NPSUS;
                        default: nxt_state = state;
                    endcase
                end
                OP_RESUME: begin
                    case (state)
                        ST_PSUS:  nxt_state = ST_PGM;
                        ST_ESUS:  nxt_state = ST_ERS;
                        ST_NPSUS: nxt_state = ST_NPGM;
                        default:  nxt_state = state;
                    endcase
                end
                default: nxt_state = nxt_state;
            endcase
        end
    end

endmodule

// File: rtl/flash_arb_state.sv
// Module: flash_arb_state
// Holds the arbiter state and the targets of the program and the erase, and
// forms the visible busy/suspend outputs from them.
// Assumes: load enables come only with a granted start of that kind.
module flash_arb_state
    import flash_arb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 4,
    parameter int BLK_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arb_state_e        nxt_state,
    input  logic              ld_pgm,
    input  logic              ld_ers,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [BLK_W-1:0]  cmd_block,
    output arb_state_e        state,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [BANK_W-1:0] pgm_bank,
    output logic [BANK_W-1:0] ers_bank,
    output logic [BLK_W-1:0]  ers_block,
    output logic              busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic [BLK_W-1:0]  busy_block,
    output logic              ers_susp,
    output logic              pgm_susp
);
    logic [BLK_W-1:0] pgm_block;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Program target: full word address plus its bank and block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_addr  <= '0;
            pgm_bank  <= '0;
            pgm_block <= '0;
        end else if (ld_pgm) begin
            pgm_addr  <= cmd_addr;
            pgm_bank  <= cmd_bank;
            pgm_block <= cmd_block;
        end
    end

    // Erase target: bank and block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ers_bank  <= '0;
            ers_block <= '0;
        end else if (ld_ers) begin
            ers_bank  <= cmd_bank;
            ers_block <= cmd_block;
        end
    end

    // Visible outputs: the program when one exists, else the erase.
    always_comb begin
        busy       = 1'b1;
        busy_bank  = pgm_bank;
        busy_block = pgm_block;
        ers_susp   = 1'b0;
        pgm_susp   = 1'b0;
        case (state)
            ST_IDLE: begin
                busy       = 1'b0;
                busy_bank  = '0;
                busy_block = '0;
            end
            ST_PSUS:  pgm_susp = 1'b1;
            ST_ERS: begin
                busy_bank  = ers_bank;
                busy_block = ers_block;
            end
            ST_ESUS: begin
                busy_bank  = ers_bank;
                busy_block = ers_block;
                ers_susp   = 1'b1;
            end
            ST_NPGM:  ers_susp = 1'b1;
            ST_NPSUS: begin
                ers_susp = 1'b1;
                pgm_susp = 1'b1;
            end
            default: busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_bank_arbiter.sv
// Module: flash_bank_arbiter (top)
// Arbitrates read, program, erase, suspend and resume requests across the
// banks of a multi-bank NOR array, answering each in the same cycle.
// Assumes: param_top is static while an operation is in flight; done is a
// one-cycle pulse from the program/erase controller.
module flash_bank_arbiter
    import flash_arb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BANK_W  = 4,
    parameter int MAIN_W  = 16,
    parameter int PARAM_W = 14,
    parameter int BLK_W   = $clog2((1 << (ADDR_W - MAIN_W)) - 1 + (1 << (MAIN_W - PARAM_W)))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              param_top,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              done,
    output logic              grant,
    output logic              reject,
    output logic              busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic [BLK_W-1:0]  busy_block,
    output logic              ers_susp,
    output logic              pgm_susp
);
    arb_state_e        state;
    arb_state_e        nxt_state;
    logic [BANK_W-1:0] cmd_bank;
    logic [BLK_W-1:0]  cmd_block;
    logic [ADDR_W-1:0] pgm_addr;
    logic [BANK_W-1:0] pgm_bank;
    logic [BANK_W-1:0] ers_bank;
    logic [BLK_W-1:0]  ers_block;
    logic              ld_pgm;
    logic              ld_ers;

    flash_addr_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAIN_W(MAIN_W),
        .PARAM_W(PARAM_W), .BLK_W(BLK_W)
    ) i_decode (
        .addr(cmd_addr), .param_top(param_top),
        .bank(cmd_bank), .block(cmd_block)
    );

    flash_arb_decide #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)
    ) i_decide (
        .state(state), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .done(done),
        .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_block(cmd_block),
        .pgm_addr(pgm_addr), .pgm_bank(pgm_bank),
        .ers_bank(ers_bank), .ers_block(ers_block),
        .grant(grant), .reject(reject),
        .ld_pgm(ld_pgm), .ld_ers(ld_ers), .nxt_state(nxt_state)
    );

    flash_arb_state #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)
    ) i_state (
        .clk(clk), .rst_n(rst_n), .nxt_state(nxt_state),
        .ld_pgm(ld_pgm), .ld_ers(ld_ers),
        .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_block(cmd_block),
        .state(state), .pgm_addr(pgm_addr), .pgm_bank(pgm_bank),
        .ers_bank(ers_bank), .ers_block(ers_block),
        .busy(busy), .busy_bank(busy_bank), .busy_block(busy_block),
        .ers_susp(ers_susp), .pgm_susp(pgm_susp)
    );

endmodule

// File: rtl/flash_arb_chk.sv
// Module: flash_arb_chk
// Port-level properties of the arbiter, bound into every instance.
// Assumes: synchronous active-low reset; opcodes as in flash_arb_pkg.
module flash_arb_chk
    import flash_arb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 4,
    parameter int BLK_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              done,
    input logic              grant,
    input logic              reject,
    input logic              busy,
    input logic [BANK_W-1:0] busy_bank,
    input logic [BLK_W-1:0]  busy_block,
    input logic              ers_susp,
    input logic              pgm_susp
);
    logic [BANK_W-1:0] req_bank;
    logic              running;
    assign req_bank = cmd_addr[ADDR_W-1:ADDR_W-BANK_W];
    assign running  = busy && !ers_susp && !pgm_susp;

    // R4: never both flags, and no flag without a command
    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || reject) |-> (cmd_valid && !(grant && reject)));

    // R5: a granted first program becomes the busy operation on its bank
    a_r5_start_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROG && grant && !busy)
        |=> (busy && busy_bank == $past(req_bank) && !pgm_susp));

    // R6: read to another bank during a running program/erase is granted
    a_r6_read_other: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && running && req_bank != busy_bank)
        |-> grant);

    // R6: read to the busy bank during a running operation is rejected
    a_r6_read_same: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ && running && !ers_susp && req_bank == busy_bank)
        |-> reject);

    // R7: a second erase is refused whenever anything is in flight
    a_r7_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE && busy) |-> reject);

    // R11: resume with nothing suspended raises no flag
    a_r11_resume_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESUME && !ers_susp && !pgm_susp)
        |-> (!grant && !reject));

    // R11: and leaves the busy outputs as they were
    a_r11_resume_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RESUME && !ers_susp && !pgm_susp && !done)
        |=> ($stable(busy) && $stable(busy_bank) && $stable(busy_block)));

    // R12: done on a plain running operation returns to idle
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && running) |=> !busy);

    // R8: a suspend flag implies an operation is held
    a_r8_susp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_susp || pgm_susp) |-> busy);

endmodule

bind flash_bank_arbiter flash_arb_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BLK_W(BLK_W)
) i_flash_arb_chk (.*);

// File: tb/test_flash_bank_arbiter.sv
module test_flash_bank_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        param_top = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [23:0] cmd_addr = '0;
    logic        done = 1'b0;
    logic        grant, reject, busy, ers_susp, pgm_susp;
    logic [3:0]  busy_bank;
    logic [8:0]  busy_block;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_bank_arbiter i_flash_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .param_top(param_top),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .done(done), .grant(grant), .reject(reject), .busy(busy),
        .busy_bank(busy_bank), .busy_block(busy_block),
        .ers_susp(ers_susp), .pgm_susp(pgm_susp)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic        v;
        logic [23:0] a;
        logic        dn;
        logic        top;
        logic        g;
        logic        r;
        logic        b;
        logic [3:0]  bk;
        logic [8:0]  blk;
        logic        es;
        logic        ps;
        logic [7:0]  rq;
    } vec_t;

    function automatic vec_t mk(int op, int v, int a, int dn, int top, int g,
                                int r, int b, int bk, int blk, int es, int ps, int rq);
        vec_t t;
        t.op = 3'(op);  t.v = 1'(v);   t.a = 24'(a);  t.dn = 1'(dn);
        t.top = 1'(top); t.g = 1'(g);  t.r = 1'(r);   t.b = 1'(b);
        t.bk = 4'(bk);  t.blk = 9'(blk); t.es = 1'(es); t.ps = 1'(ps);
        t.rq = 8'(rq);
        return t;
    endfunction

    localparam int NV = 56;
    // op v addr dn top | g r | busy bank block es ps | req
    localparam vec_t TBL [NV] = '{
        mk(0,1,'h500000,0,0, 1,0, 0,0,0,0,0, 5),    // R5 idle read
        mk(3,1,'h000000,0,0, 0,1, 0,0,0,0,0, 8),    // R8 suspend idle
        mk(4,1,'h000000,0,0, 0,0, 0,0,0,0,0, 11),   // R11 resume idle
        mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12),   // R12 done idle
        mk(1,1,'h230000,0,0, 1,0, 1,2,38,0,0, 2),   // R2 program blk 38
        mk(0,1,'h200000,0,0, 0,1, 1,2,38,0,0, 6),   // R6 same bank
        mk(0,1,'h500000,0,0, 1,0, 1,2,38,0,0, 6),   // R6 other bank
        mk(2,1,'h700000,0,0, 0,1, 1,2,38,0,0, 7),   // R7 erase refused
        mk(1,1,'h100000,0,0, 0,1, 1,2,38,0,0, 7),   // R7 program refused
        mk(4,1,'h000000,0,0, 0,0, 1,2,38,0,0, 11),  // R11 resume ignored
        mk(3,1,'h000000,0,0, 1,0, 1,2,38,0,1, 8),   // R8 suspend program
        mk(0,0,'h000000,1,0, 0,0, 1,2,38,0,1, 12),  // R12 done while suspended
        mk(0,1,'h230000,0,0, 0,1, 1,2,38,0,1, 10),  // R10 programmed word
        mk(0,1,'h230001,0,0, 1,0, 1,2,38,0,1, 10),  // R10 neighbour word
        mk(1,1,'h100000,0,0, 0,1, 1,2,38,0,1, 7),   // R7
        mk(3,1,'h000000,0,0, 0,1, 1,2,38,0,1, 8),   // R8 second suspend
        mk(4,1,'h000000,0,0, 1,0, 1,2,38,0,0, 8),   // R8 resume
        mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12),   // R12 done
        mk(2,1,'h008000,0,0, 1,0, 1,0,2,0,0, 2),    // R2 erase param blk 2
        mk(0,1,'h00C000,0,0, 0,1, 1,0,2,0,0, 6),    // R6
        mk(3,1,'h000000,0,0, 1,0, 1,0,2,1,0, 8),    // R8 suspend erase
        mk(0,1,'h008010,0,0, 0,1, 1,0,2,1,0, 9),    // R9 erase block read
        mk(0,1,'h004000,0,0, 1,0, 1,0,2,1,0, 9),    // R9 other block read
        mk(2,1,'h300000,0,0, 0,1, 1,0,2,1,0, 7),    // R7
        mk(1,1,'h00A000,0,0, 0,1, 1,0,2,1,0, 9),    // R9 program erase block
        mk(1,1,'h010000,0,0, 1,0, 1,0,4,1,0, 9),    // R9 nested program blk 4
        mk(0,1,'h020000,0,0, 0,1, 1,0,4,1,0, 9),    // R9 program bank read
        mk(0,1,'h400000,0,0, 1,0, 1,0,4,1,0, 9),    // R9
        mk(4,1,'h000000,0,0, 0,1, 1,0,4,1,0, 9),    // R9 resume refused
        mk(3,1,'h000000,0,0, 1,0, 1,0,4,1,1, 8),    // R8 nested suspend
        mk(0,1,'h010000,0,0, 0,1, 1,0,4,1,1, 10),   // R10
        mk(0,1,'h008000,0,0, 0,1, 1,0,4,1,1, 10),   // R10 erase block
        mk(0,1,'h020000,0,0, 1,0, 1,0,4,1,1, 10),   // R10
        mk(4,1,'h000000,0,0, 1,0, 1,0,4,1,0, 8),    // R8
        mk(0,0,'h000000,1,0, 0,0, 1,0,2,1,0, 9),    // R9 back to erase
        mk(4,1,'h000000,0,0, 1,0, 1,0,2,0,0, 8),    // R8 resume erase
        mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12),   // R12
        mk(2,1,'hFFC000,0,1, 1,0, 1,15,258,0,0, 3), // R3 top param blk 258
        mk(0,0,'h000000,1,1, 0,0, 0,0,0,0,0, 12),
        mk(1,1,'hF00000,0,1, 1,0, 1,15,240,0,0, 3), // R3
        mk(6,1,'hF00000,0,1, 0,1, 1,15,240,0,0, 4), // R4 undefined opcode
        mk(0,1,'hF00000,1,1, 0,1, 0,0,0,0,0, 12),   // R12 done with read
        mk(2,1,'h000000,0,1, 1,0, 1,0,0,0,0, 3),    // R3 blk 0
        mk(3,1,'h000000,1,1, 0,1, 0,0,0,0,0, 8),    // R8 suspend with done
        mk(1,1,'h1F0000,0,1, 1,0, 1,1,31,0,0, 3),   // R3 blk 31
        mk(0,0,'h000000,1,1, 0,0, 0,0,0,0,0, 12),
        mk(2,1,'hF3C000,0,1, 1,0, 1,15,243,0,0, 3), // R3 blk 243
        mk(0,0,'h000000,1,1, 0,0, 0,0,0,0,0, 12),
        mk(2,1,'hFE0000,0,1, 1,0, 1,15,254,0,0, 3), // R3 blk 254
        mk(0,0,'h000000,1,1, 0,0, 0,0,0,0,0, 12),
        mk(2,1,'hFF0000,0,0, 1,0, 1,15,258,0,0, 2), // R2 blk 258
        mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12),
        mk(2,1,'h00C000,0,0, 1,0, 1,0,3,0,0, 2),    // R2 blk 3
        mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12),
        mk(5,1,'h000000,0,0, 0,1, 0,0,0,0,0, 4),    // R4 undefined in idle
        mk(7,1,'h000000,0,0, 0,1, 0,0,0,0,0, 4)     // R4
    };

    task automatic check_flags(input logic g, input logic r, input int rq, input int idx);
        checks++;
        if (grant !== g || reject !== r) begin
            errors++;
            $display("FAIL R%0d step %0d flags: grant=%b reject=%b expected grant=%b reject=%b",
                     rq, idx, grant, reject, g, r);
        end
    endtask

    task automatic check_state(input logic b, input logic [3:0] bk, input logic [8:0] blk,
                               input logic es, input logic ps, input int rq, input int idx);
        checks++;
        if (busy !== b || busy_bank !== bk || busy_block !== blk ||
            ers_susp !== es || pgm_susp !== ps) begin
            errors++;
            $display("FAIL R%0d step %0d state: busy=%b bank=%0d block=%0d es=%b ps=%b expected %b %0d %0d %b %b",
                     rq, idx, busy, busy_bank, busy_block, ers_susp, pgm_susp, b, bk, blk, es, ps);
        end
    endtask

    task automatic apply(input vec_t t, input int idx);
        @(negedge clk);
        cmd_op    = t.op;
        cmd_valid = t.v;
        cmd_addr  = t.a;
        done      = t.dn;
        param_top = t.top;
        #2;
        check_flags(t.g, t.r, int'(t.rq), idx);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        done      = 1'b0;
        check_state(t.b, t.bk, t.blk, t.es, t.ps, int'(t.rq), idx);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R13 reset state
        check_state(1'b0, 4'd0, 9'd0, 1'b0, 1'b0, 13, -1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(TBL[i], i);

        // R13: reset in the middle of a suspended erase
        apply(mk(2,1,'h600000,0,0, 1,0, 1,6,99,0,0, 2), 100);
        apply(mk(3,1,'h000000,0,0, 1,0, 1,6,99,1,0, 8), 101);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_state(1'b0, 4'd0, 9'd0, 1'b0, 1'b0, 13, 102);
        @(negedge clk);
        rst_n = 1'b1;
        // R13: after reset a resume has nothing to resume (R11)
        apply(mk(4,1,'h000000,0,0, 0,0, 0,0,0,0,0, 11), 103);
        // R1: bank field comes from bits [23:20]
        apply(mk(1,1,'hA12345,0,0, 1,0, 1,10,3+160+1,0,0, 1), 104);
        apply(mk(0,1,'hAFFFFF,0,0, 0,1, 1,10,164,0,0, 6), 105);
        apply(mk(0,1,'h9FFFFF,0,0, 1,0, 1,10,164,0,0, 6), 106);
        apply(mk(0,0,'h000000,1,0, 0,0, 0,0,0,0,0, 12), 107);

        finished = 1'b1;
        finish_run();
    end

endmodule